// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the combinational front of a fetch stage for a small byte-oriented instruction set with a 64-bit word. It receives a window of ten bytes read from instruction memory at the current program counter, together with a flag saying that the fetch address was bad. From the window it extracts the operation and variant nibbles, the two register specifiers, and an 8-byte constant. It also computes the address of the following instruction.

Instructions are one, two, nine or ten bytes long. The length depends on whether the operation carries a register byte and whether it carries a constant word. When the fetch flag reports a bad address, the fetched bytes are disregarded as an instruction and a no-operation is presented in their place. The program counter register, register access and status handling sit outside the block.

Top module: `fetch_decode`

## Requirements
- R1: With `fetch_err_i` low, `opcode_o` is the upper nibble and `func_o` the lower nibble of window byte 0, where byte k occupies `win_i[8k+7:8k]`.
- R2: With `fetch_err_i` high, `opcode_o` is 1 and `func_o` is 0 whatever the window holds, and every other output follows from opcode 1.
- R3: `legal_o` is 1 exactly when `opcode_o` is in the range 0 to 11, and 0 for 12 to 15.
- R4: `has_regs_o` is 1 exactly for opcodes 2, 3, 4, 5, 6, 10 and 11. When it is set, `ra_o` is the upper and `rb_o` the lower nibble of byte 1; otherwise both are 15.
- R5: `has_const_o` is 1 exactly for opcodes 3, 4, 5, 7 and 8.
- R6: `const_o` is the 8 bytes taken little-endian, starting at byte 2 when `has_regs_o` is set and at byte 1 otherwise. It is driven this way whether or not `has_const_o` is set.
- R7: `next_pc_o` equals `pc_i + 1 + has_regs_o + 8*has_const_o`, taken modulo 2^64, so that an address near the top of memory wraps around to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of the instruction byte |
| win_i | input | 80 | Ten fetched bytes, byte 0 in the low bits |
| fetch_err_i | input | 1 | The fetch address was invalid |
| opcode_o | output | 4 | Operation code |
| func_o | output | 4 | Variant code |
| ra_o | output | 4 | First register specifier |
| rb_o | output | 4 | Second register specifier |
| const_o | output | 64 | Constant word |
| next_pc_o | output | 64 | Address of the following instruction |
| legal_o | output | 1 | Operation code is defined |
| has_regs_o | output | 1 | Instruction carries a register byte |
| has_const_o | output | 1 | Instruction carries a constant word |

## Verification
The bench builds the block with its default 64-bit word and 64-bit address. With these values the window is ten bytes, and all four instruction lengths can be reached. The address width makes the wrap of the next address at the top of memory reachable with a directed case. Random windows cover every opcode nibble including the undefined ones, with and without a fetch error, and random addresses near the top of memory exercise the carry through the full 64-bit sum.

// File: rtl/fetch_decode.sv
module fetch_decode #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 64,
  localparam int CB    = WORD_W / 8,
  localparam int WIN   = CB + 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [8*WIN-1:0]  win_i,
  input  logic              fetch_err_i,
  output logic [3:0]        opcode_o,
  output logic [3:0]        func_o,
  output logic [3:0]        ra_o,
  output logic [3:0]        rb_o,
  output logic [WORD_W-1:0] const_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              legal_o,
  output logic              has_regs_o,
  output logic              has_const_o
);
  assign opcode_o = fetch_err_i ? 4'h1 : win_i[7:4];
  assign func_o   = fetch_err_i ? 4'h0 : win_i[3:0];

  always_comb begin
    has_regs_o  = 1'b0;
    has_const_o = 1'b0;
    case (opcode_o)
      4'h2, 4'h6, 4'hA, 4'hB: has_regs_o = 1'b1;
      4'h3, 4'h4, 4'h5: begin
        has_regs_o  = 1'b1;
        has_const_o = 1'b1;
      end
      4'h7, 4'h8: has_const_o = 1'b1;
      default: ;
    endcase
  end

  assign legal_o = (opcode_o <= 4'hB);
  assign ra_o    = has_regs_o ? win_i[15:12] : 4'hF;
  assign rb_o    = has_regs_o ? win_i[11:8]  : 4'hF;

  for (genvar i = 0; i < CB; i++) begin : g_cbyte
    assign const_o[8*i +: 8] = has_regs_o ? win_i[8*(i+2) +: 8] : win_i[8*(i+1) +: 8];
  end

  assign next_pc_o = pc_i + ADDR_W'(1) + ADDR_W'(has_regs_o)
                   + (has_const_o ? ADDR_W'(CB) : '0);
endmodule

// File: rtl/fetch_decode_chk.sv
module fetch_decode_chk #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 64,
  localparam int CB    = WORD_W / 8,
  localparam int WIN   = CB + 2
) (
  input logic [ADDR_W-1:0] pc_i,
  input logic [8*WIN-1:0]  win_i,
  input logic              fetch_err_i,
  input logic [3:0]        opcode_o,
  input logic [3:0]        func_o,
  input logic [3:0]        ra_o,
  input logic [3:0]        rb_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              legal_o,
  input logic              has_regs_o,
  input logic              has_const_o
);
  logic [ADDR_W-1:0] step;
  assign step = next_pc_o - pc_i;

  always_comb begin
    if (fetch_err_i) begin
      p_err_nop_r2: assert (opcode_o == 4'h1 && func_o == 4'h0 && !has_regs_o && !has_const_o);
    end
    if (!legal_o) begin
      p_illegal_short_r3: assert (opcode_o > 4'hB && step == ADDR_W'(1));
    end
    if (!has_regs_o) begin
      p_noregs_r4: assert (ra_o == 4'hF && rb_o == 4'hF);
    end
    if (has_const_o && !has_regs_o) begin
      p_branch_const_r5: assert (opcode_o == 4'h7 || opcode_o == 4'h8);
    end
    p_len_r7: assert (step == ADDR_W'(1) || step == ADDR_W'(2)
                   || step == ADDR_W'(CB + 1) || step == ADDR_W'(CB + 2));
  end
endmodule

bind fetch_decode fetch_decode_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .pc_i(pc_i), .win_i(win_i), .fetch_err_i(fetch_err_i),
  .opcode_o(opcode_o), .func_o(func_o), .ra_o(ra_o), .rb_o(rb_o),
  .next_pc_o(next_pc_o), .legal_o(legal_o),
  .has_regs_o(has_regs_o), .has_const_o(has_const_o)
);

// File: tb/fetch_decode_tb.sv
module fetch_decode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [63:0] pc;
  logic [79:0] win;
  logic        err;
  logic [3:0]  opc, fn, ra, rb;
  logic [63:0] cval, npc;
  logic        legal, hreg, hcon;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mem [10];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_decode dut_i (
    .pc_i(pc), .win_i(win), .fetch_err_i(err),
    .opcode_o(opc), .func_o(fn), .ra_o(ra), .rb_o(rb),
    .const_o(cval), .next_pc_o(npc), .legal_o(legal),
    .has_regs_o(hreg), .has_const_o(hcon)
  );

  function automatic logic e_regs(input logic [3:0] o);
    return o inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
  endfunction
  function automatic logic e_const(input logic [3:0] o);
    return o inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [63:0] a, input logic e);
    logic [3:0]  xo, xf, xa, xb;
    logic        xr, xc;
    logic [63:0] xv;
    int          base;
    @(negedge clk);
    pc  = a;
    err = e;
    for (int k = 0; k < 10; k++) win[8*k +: 8] = mem[k];
    xo = e ? 4'h1 : mem[0][7:4];
    xf = e ? 4'h0 : mem[0][3:0];
    xr = e_regs(xo);
    xc = e_const(xo);
    xa = xr ? mem[1][7:4] : 4'hF;
    xb = xr ? mem[1][3:0] : 4'hF;
    base = xr ? 2 : 1;
    xv = '0;
    for (int k = 7; k >= 0; k--) xv = {xv[55:0], mem[base + k]};
    #1;
    chk(e ? "R2 opcode" : "R1 opcode", 64'(opc), 64'(xo));
    chk(e ? "R2 func"   : "R1 func",   64'(fn),  64'(xf));
    chk("R3 legal", 64'(legal), 64'(xo <= 4'hB));
    chk("R4 has_regs", 64'(hreg), 64'(xr));
    chk("R4 ra", 64'(ra), 64'(xa));
    chk("R4 rb", 64'(rb), 64'(xb));
    chk("R5 has_const", 64'(hcon), 64'(xc));
    chk("R6 const", cval, xv);
    chk("R7 next_pc", npc, a + 64'd1 + 64'(xr) + (xc ? 64'd8 : 64'd0));
  endtask

  initial begin
    pc = '0; win = '0; err = 1'b0;
    void'($urandom(32'd2024));
    for (int k = 0; k < 10; k++) mem[k] = 8'(k * 17 + 3);

    // directed: each opcode, no error
    for (int o = 0; o < 16; o++) begin
      mem[0] = {4'(o), 4'h5};
      mem[1] = 8'h3C;
      apply_and_check(64'h1000 + 64'(o), 1'b0);
    end
    // R2: error over a call-like window
    mem[0] = 8'h80;
    apply_and_check(64'h2000, 1'b1);
    // R7: wrap at the top of memory with a ten-byte instruction
    mem[0] = 8'h40;
    apply_and_check(64'hFFFF_FFFF_FFFF_FFFA, 1'b0);
    // R7: nine-byte instruction ending exactly at wrap
    mem[0] = 8'h70;
    apply_and_check(64'hFFFF_FFFF_FFFF_FFF7, 1'b0);

    // random windows
    for (int t = 0; t < 1500; t++) begin
      for (int k = 0; k < 10; k++) mem[k] = 8'($urandom);
      apply_and_check((t % 5 == 0) ? ~64'($urandom_range(0, 20))
                                   : {32'($urandom), 32'($urandom)},
                      ($urandom_range(0, 7) == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule